// File: doc/BRIEF.md
# Dual-Address Synchronous SRAM with Cross-Port Forwarding

This block is a synthesizable memory with two independent ports, X and Y. Each port has its own address, its own write-data bus and its own read-data bus. Every synchronous input is captured on the rising clock edge. This includes the two chip-select levels, the write strobe, the forward strobe, the address and the write data. The captured operation runs in the following cycle. Its read result lands in a per-port output register. The output enable is the only input that does not wait for the clock. It masks the read-valid flag directly.

Each port can read, write or forward in every cycle. A forward copies the port's own captured write data onto the opposite port's read register, skipping the array. A forward into a port beats an array read on that port. Collisions at the same address have fixed outcomes. Two reads both see the stored word. A read paired with a write sees the old word. When both ports write the same address, port Y's data is kept.

The read side is a valid-only stream. There is no ready input, so the block never stalls and never applies back-pressure. Read data stays on `*_rdata` until the next accepted read or forward on that port. `*_rvalid` is high for exactly the cycle that follows an accepted read or forward edge, and only while the output enable is low. A consumer that cannot take the word must re-read it.

Top module: `dual_addr_sram_fwd`

## Requirements
- R1: A read presented before rising edge N is captured at N. Its data and valid appear after edge N+1. After edge N alone, valid is not yet raised by that read.
- R2: A port is active only when `sel_n` is 0 and `sel` is 1. Any other pair is a deselect cycle: no array write, no read output, and no forward out of or into that port.
- R3: An active port with `wr_n` = 0 stores its captured `wdata` at its captured `addr`.
- R4: An active port with `wr_n` = 1 and no forward arriving from the other port returns the stored word at its address, with valid high.
- R5: When both ports are active and `x_fwd_n` is 0, port Y's output becomes port X's captured `x_wdata`, whatever X's own operation is. `y_fwd_n` = 0 does the same from Y to X. Both directions may run in the same cycle.
- R6: A forward arriving at a port replaces that port's array read data.
- R7: Two reads of the same address in one cycle both return the stored word.
- R8: A write and a read of the same address in one cycle: the reader gets the word stored before the write, and the new word is visible from the next cycle on.
- R9: Two writes to the same address in one cycle store only port Y's data.
- R10: While a port's `out_en_n` is 1, its `rvalid` is 0 without any clock edge. `rdata` is unaffected, and valid returns when `out_en_n` drops.
- R11: Synchronous active-high `rst` clears the captured inputs and both output registers. No valid appears until a read or forward has been captured and completed after reset.
- R12: An output cycle that follows a write, a deselect or a reset on a port, with no forward into it, leaves that port's `rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_sel_n | input | 1 | Port X select, active low |
| x_sel | input | 1 | Port X select, active high |
| x_wr_n | input | 1 | Port X write strobe, active low |
| x_fwd_n | input | 1 | Forward X write data to port Y output, active low |
| x_addr | input | ADDR_W | Port X address |
| x_wdata | input | DATA_W | Port X write data |
| x_out_en_n | input | 1 | Port X output enable, active low, unclocked |
| x_rdata | output | DATA_W | Port X read data register |
| x_rvalid | output | 1 | Port X read data valid |
| y_sel_n | input | 1 | Port Y select, active low |
| y_sel | input | 1 | Port Y select, active high |
| y_wr_n | input | 1 | Port Y write strobe, active low |
| y_fwd_n | input | 1 | Forward Y write data to port X output, active low |
| y_addr | input | ADDR_W | Port Y address |
| y_wdata | input | DATA_W | Port Y write data |
| y_out_en_n | input | 1 | Port Y output enable, active low, unclocked |
| y_rdata | output | DATA_W | Port Y read data register |
| y_rvalid | output | 1 | Port Y read data valid |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 16. A 16-word array lets one directed sweep write and read back every location, which reaches the top and bottom address decode. The 16-bit words keep every forwarded and collided value distinct in the table. The same small depth makes same-address collisions, forwards in both directions and deselected writes quick to set up and check against hand-derived results.

// File: rtl/dafs_pkg.sv
package dafs_pkg;

  // Decoded, registered per-port control for the operating cycle
  typedef struct packed {
    logic on;   // port selected
    logic wr;   // write requested
    logic fwd;  // forward own write data to the opposite port
  } port_ctl_t;

  // Source chosen for a port's output register
  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_ARRAY = 2'd1,
    OUT_FWD   = 2'd2
  } out_src_t;

endpackage

// File: rtl/dafs_port_reg.sv
module dafs_port_reg
  import dafs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              fwd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_ctl_t         ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  // Capture every synchronous input; active-low strobes become active-high
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ctl_q.on  <= !sel_n && sel;
      ctl_q.wr  <= !wr_n;
      ctl_q.fwd <= !fwd_n;
      addr_q    <= addr;
      data_q    <= wdata;
    end
  end

endmodule

// File: rtl/dafs_array.sv
module dafs_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              x_we,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [DATA_W-1:0] x_wdata,
  input  logic              y_we,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [DATA_W-1:0] y_wdata,
  output logic [DATA_W-1:0] x_rdata,
  output logic [DATA_W-1:0] y_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rows [DEPTH];

  // One register per word; port Y is checked first so it wins a shared row
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [DATA_W-1:0] word_q;
    logic              hit_x;
    logic              hit_y;

    assign hit_x = x_we && (x_addr == ADDR_W'(r));
    assign hit_y = y_we && (y_addr == ADDR_W'(r));

    always_ff @(posedge clk) begin
      if (hit_y)      word_q <= y_wdata;
      else if (hit_x) word_q <= x_wdata;
    end

    assign rows[r] = word_q;
  end

  // Reads are combinational from the captured addresses; the output register
  // samples them on the same edge that commits writes, giving read-before-write
  assign x_rdata = rows[x_addr];
  assign y_rdata = rows[y_addr];

endmodule

// File: rtl/dafs_out_stage.sv
module dafs_out_stage
  import dafs_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_rd,
  input  logic              fwd_in,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  out_src_t          src;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  // Forward beats array read
  always_comb begin
    if (fwd_in)      src = OUT_FWD;
    else if (own_rd) src = OUT_ARRAY;
    else             src = OUT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      case (src)
        OUT_FWD: begin
          data_q <= fwd_data;
          vld_q  <= 1'b1;
        end
        OUT_ARRAY: begin
          data_q <= arr_data;
          vld_q  <= 1'b1;
        end
        default: vld_q <= 1'b0;
      endcase
    end
  end

  assign rdata  = data_q;
  assign rvalid = vld_q && !out_en_n;

endmodule

// File: rtl/dual_addr_sram_fwd.sv
module dual_addr_sram_fwd
  import dafs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x_sel_n,
  input  logic              x_sel,
  input  logic              x_wr_n,
  input  logic              x_fwd_n,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [DATA_W-1:0] x_wdata,
  input  logic              x_out_en_n,
  output logic [DATA_W-1:0] x_rdata,
  output logic              x_rvalid,
  input  logic              y_sel_n,
  input  logic              y_sel,
  input  logic              y_wr_n,
  input  logic              y_fwd_n,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [DATA_W-1:0] y_wdata,
  input  logic              y_out_en_n,
  output logic [DATA_W-1:0] y_rdata,
  output logic              y_rvalid
);

  port_ctl_t         x_ctl, y_ctl;
  logic [ADDR_W-1:0] x_addr_q, y_addr_q;
  logic [DATA_W-1:0] x_data_q, y_data_q;
  logic [DATA_W-1:0] x_arr, y_arr;
  logic              both_on, fwd_xy, fwd_yx;

  dafs_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_x_in (
    .clk(clk), .rst(rst),
    .sel_n(x_sel_n), .sel(x_sel), .wr_n(x_wr_n), .fwd_n(x_fwd_n),
    .addr(x_addr), .wdata(x_wdata),
    .ctl_q(x_ctl), .addr_q(x_addr_q), .data_q(x_data_q)
  );

  dafs_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_y_in (
    .clk(clk), .rst(rst),
    .sel_n(y_sel_n), .sel(y_sel), .wr_n(y_wr_n), .fwd_n(y_fwd_n),
    .addr(y_addr), .wdata(y_wdata),
    .ctl_q(y_ctl), .addr_q(y_addr_q), .data_q(y_data_q)
  );

  // Forwarding needs both ports selected
  assign both_on = x_ctl.on && y_ctl.on;
  assign fwd_xy  = both_on && x_ctl.fwd;
  assign fwd_yx  = both_on && y_ctl.fwd;

  dafs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .x_we(x_ctl.on && x_ctl.wr), .x_addr(x_addr_q), .x_wdata(x_data_q),
    .y_we(y_ctl.on && y_ctl.wr), .y_addr(y_addr_q), .y_wdata(y_data_q),
    .x_rdata(x_arr), .y_rdata(y_arr)
  );

  dafs_out_stage #(.DATA_W(DATA_W)) u_x_out (
    .clk(clk), .rst(rst),
    .own_rd(x_ctl.on && !x_ctl.wr), .fwd_in(fwd_yx), .fwd_data(y_data_q),
    .arr_data(x_arr), .out_en_n(x_out_en_n),
    .rdata(x_rdata), .rvalid(x_rvalid)
  );

  dafs_out_stage #(.DATA_W(DATA_W)) u_y_out (
    .clk(clk), .rst(rst),
    .own_rd(y_ctl.on && !y_ctl.wr), .fwd_in(fwd_xy), .fwd_data(x_data_q),
    .arr_data(y_arr), .out_en_n(y_out_en_n),
    .rdata(y_rdata), .rvalid(y_rvalid)
  );

endmodule

// File: rtl/dual_addr_sram_fwd_chk.sv
module dual_addr_sram_fwd_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              x_sel_n,
  input logic              x_sel,
  input logic              x_wr_n,
  input logic              x_fwd_n,
  input logic [ADDR_W-1:0] x_addr,
  input logic [DATA_W-1:0] x_wdata,
  input logic              x_out_en_n,
  input logic [DATA_W-1:0] x_rdata,
  input logic              x_rvalid,
  input logic              y_sel_n,
  input logic              y_sel,
  input logic              y_wr_n,
  input logic              y_fwd_n,
  input logic [ADDR_W-1:0] y_addr,
  input logic [DATA_W-1:0] y_wdata,
  input logic              y_out_en_n,
  input logic [DATA_W-1:0] y_rdata,
  input logic              y_rvalid
);

  logic [1:0] age;
  logic       x_on, y_on;

  assign x_on = !x_sel_n && x_sel;
  assign y_on = !y_sel_n && y_sel;

  // Edges since reset, saturating at the two-cycle pipeline depth
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_X_OE_MASK: assert property (@(posedge clk) disable iff (rst)
    x_out_en_n |-> !x_rvalid); // R10
  AST_Y_OE_MASK: assert property (@(posedge clk) disable iff (rst)
    y_out_en_n |-> !y_rvalid); // R10

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!x_rvalid && !y_rvalid)); // R11

  AST_FWD_X_TO_Y: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(x_on && y_on && !x_fwd_n, 2) && !y_out_en_n)
      |-> (y_rvalid && y_rdata == $past(x_wdata, 2))); // R5
  AST_FWD_Y_TO_X: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(x_on && y_on && !y_fwd_n, 2) && !x_out_en_n)
      |-> (x_rvalid && x_rdata == $past(y_wdata, 2))); // R5

  AST_X_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(!x_on, 2)) |-> !x_rvalid); // R2
  AST_Y_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(!y_on, 2)) |-> !y_rvalid); // R2

  AST_X_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(x_on && !x_wr_n && !(y_on && !y_fwd_n), 2))
      |-> !x_rvalid); // R12
  AST_Y_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(y_on && !y_wr_n && !(x_on && !x_fwd_n), 2))
      |-> !y_rvalid); // R12

endmodule

bind dual_addr_sram_fwd dual_addr_sram_fwd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dual_addr_sram_fwd.sv
`timescale 1ns/100ps
module tb_dual_addr_sram_fwd;

  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_sel_n, x_sel, x_wr_n, x_fwd_n, x_out_en_n;
  logic y_sel_n, y_sel, y_wr_n, y_fwd_n, y_out_en_n;
  logic [AW-1:0] x_addr, y_addr;
  logic [DW-1:0] x_wdata, y_wdata, x_rdata, y_rdata;
  logic x_rvalid, y_rvalid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_addr_sram_fwd #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  // xs/ys: port active; xw/yw: write; xp/yp: forward to other port
  typedef struct packed {
    logic xs; logic xw; logic xp; logic [AW-1:0] xa; logic [DW-1:0] xd;
    logic ys; logic yw; logic yp; logic [AW-1:0] ya; logic [DW-1:0] yd;
    logic exv; logic [DW-1:0] exd; logic eyv; logic [DW-1:0] eyd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,4'h1,16'h1111, 0,0,0,4'h0,16'h0000, 0,16'h0000,0,16'h0000, 3}, // R3
    '{0,0,0,4'h0,16'h0000, 1,1,0,4'h2,16'h2222, 0,16'h0000,0,16'h0000, 3}, // R3
    '{1,0,0,4'h1,16'h0000, 1,0,0,4'h2,16'h0000, 1,16'h1111,1,16'h2222, 4}, // R4
    '{1,0,0,4'h1,16'h0000, 1,0,0,4'h1,16'h0000, 1,16'h1111,1,16'h1111, 7}, // R7
    '{1,1,0,4'h1,16'hAAAA, 1,0,0,4'h1,16'h0000, 0,16'h0000,1,16'h1111, 8}, // R8
    '{1,0,0,4'h1,16'h0000, 1,0,0,4'h1,16'h0000, 1,16'hAAAA,1,16'hAAAA, 8}, // R8
    '{1,1,0,4'h3,16'h3333, 1,1,0,4'h3,16'h4444, 0,16'h0000,0,16'h0000, 9}, // R9
    '{1,0,0,4'h3,16'h0000, 1,0,0,4'h3,16'h0000, 1,16'h4444,1,16'h4444, 9}, // R9
    '{1,0,0,4'h2,16'h0000, 1,1,0,4'h2,16'h5555, 1,16'h2222,0,16'h0000, 8}, // R8
    '{1,0,0,4'h2,16'h0000, 0,0,0,4'h0,16'h0000, 1,16'h5555,0,16'h0000, 8}, // R8
    '{1,0,1,4'h1,16'hBEEF, 1,0,0,4'h2,16'h0000, 1,16'hAAAA,1,16'hBEEF, 6}, // R6
    '{1,0,0,4'h1,16'h0000, 1,0,1,4'h3,16'hCAFE, 1,16'hCAFE,1,16'h4444, 6}, // R6
    '{1,1,1,4'h5,16'h1234, 1,1,1,4'h6,16'h5678, 1,16'h5678,1,16'h1234, 5}, // R5
    '{1,0,0,4'h5,16'h0000, 1,0,0,4'h6,16'h0000, 1,16'h1234,1,16'h5678, 3}, // R3
    '{1,0,1,4'h1,16'h0F0F, 0,0,0,4'h0,16'h0000, 1,16'hAAAA,0,16'h0000, 5}, // R5
    '{0,0,1,4'h0,16'hF0F0, 1,0,0,4'h3,16'h0000, 0,16'h0000,1,16'h4444, 5}, // R5
    '{0,1,0,4'h1,16'h0000, 0,1,0,4'h1,16'h0000, 0,16'h0000,0,16'h0000, 2}, // R2
    '{1,0,0,4'h1,16'h0000, 0,0,0,4'h0,16'h0000, 1,16'hAAAA,0,16'h0000, 2}  // R2
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    x_sel_n = 1'b1; x_sel = 1'b0; x_wr_n = 1'b1; x_fwd_n = 1'b1;
    y_sel_n = 1'b1; y_sel = 1'b0; y_wr_n = 1'b1; y_fwd_n = 1'b1;
    x_addr = '0; y_addr = '0; x_wdata = '0; y_wdata = '0;
  endtask

  task automatic drive(input vec_t v);
    x_sel_n = !v.xs; x_sel = v.xs; x_wr_n = !v.xw; x_fwd_n = !v.xp;
    x_addr = v.xa; x_wdata = v.xd;
    y_sel_n = !v.ys; y_sel = v.ys; y_wr_n = !v.yw; y_fwd_n = !v.yp;
    y_addr = v.ya; y_wdata = v.yd;
  endtask

  // Present one operation, then idle; sample after the output edge
  task automatic step();
    @(posedge clk); @(negedge clk); idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] model [16];
    idle();
    x_out_en_n = 1'b0; y_out_en_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R11", "x_rvalid after reset", x_rvalid, 0);
    chk("R11", "y_rvalid after reset", y_rvalid, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      drive(VECS[i]);
      step();
      chk(tag, "x_rvalid", x_rvalid, VECS[i].exv);
      chk(tag, "y_rvalid", y_rvalid, VECS[i].eyv);
      if (VECS[i].exv) chk(tag, "x_rdata", x_rdata, VECS[i].exd);
      if (VECS[i].eyv) chk(tag, "y_rdata", y_rdata, VECS[i].eyd);
    end

    // R1: latency of two edges
    x_sel_n = 0; x_sel = 1; x_wr_n = 1; x_addr = 4'h1;
    @(posedge clk); @(negedge clk); idle();
    chk("R1", "x_rvalid after capture edge", x_rvalid, 0);
    @(posedge clk); @(negedge clk);
    chk("R1", "x_rvalid after output edge", x_rvalid, 1);
    chk("R1", "x_rdata after output edge", x_rdata, 16'hAAAA);

    // R10: output enable masks valid without a clock edge
    #0.3 x_out_en_n = 1'b1;
    #0.3 chk("R10", "x_rvalid with out_en_n high", x_rvalid, 0);
    chk("R10", "x_rdata held with out_en_n high", x_rdata, 16'hAAAA);
    #0.3 x_out_en_n = 1'b0;
    #0.3 chk("R10", "x_rvalid restored", x_rvalid, 1);

    // R12: idle output cycle drops valid
    @(posedge clk); @(negedge clk);
    chk("R12", "x_rvalid after idle cycle", x_rvalid, 0);

    // R2: both deselect encodings block writes
    x_sel_n = 1; x_sel = 1; x_wr_n = 0; x_addr = 4'h1; x_wdata = 16'h1357;
    y_sel_n = 0; y_sel = 0; y_wr_n = 0; y_addr = 4'h1; y_wdata = 16'h2468;
    step();
    chk("R2", "x_rvalid deselected", x_rvalid, 0);
    chk("R2", "y_rvalid deselected", y_rvalid, 0);
    y_sel_n = 0; y_sel = 1; y_wr_n = 1; y_addr = 4'h1;
    step();
    chk("R2", "word after deselected writes", y_rdata, 16'hAAAA);

    // R3/R4: full sweep, write via X, read via Y
    for (int a = 0; a < 16; a++) begin
      model[a] = DW'(a * 16'h0101) ^ 16'h5A5A;
      x_sel_n = 0; x_sel = 1; x_wr_n = 0; x_addr = AW'(a); x_wdata = model[a];
      step();
    end
    for (int a = 0; a < 16; a++) begin
      y_sel_n = 0; y_sel = 1; y_wr_n = 1; y_addr = AW'(a);
      step();
      chk("R4", $sformatf("y_rvalid sweep %0d", a), y_rvalid, 1);
      chk("R3", $sformatf("y_rdata sweep %0d", a), y_rdata, model[a]);
    end

    // R11: reset between capture and output cancels the read
    x_sel_n = 0; x_sel = 1; x_wr_n = 1; x_addr = 4'h2;
    @(posedge clk); @(negedge clk); idle(); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk("R11", "x_rvalid after mid-flight reset", x_rvalid, 0);
    @(posedge clk); @(negedge clk);
    chk("R11", "x_rvalid one cycle later", x_rvalid, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule